// File: doc/BRIEF.md
# Coprocessor Opcode Trap Decision Unit

This unit sits in a CPU front end beside the instruction decoder. Every operation word handed to it over a valid/ready stream is screened: words outside the coprocessor class (top nibble other than 1111) pass through with no effect. A coprocessor-class word either traps at once to the emulation exception, with no coprocessor traffic, or starts a coprocessor handshake. In the handshake phase the unit watches the interface status and the response primitive, and it may trap from there.

A trap leaves as a valid/ready record: vector, stack frame format code, the program counter of the trapping instruction and a flag telling whether a handshake had been started. The trap record is held stable until it is acknowledged. No new operation word is accepted until that happens. An invalid response primitive makes the unit write an abort mask to the coprocessor control register for one cycle, and the trap follows in the next cycle. The coprocessor's own execution and the stacking memory traffic belong to other blocks.

Stream rules: an operation word is taken on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` is high only while the unit is idle. A trap record is consumed on an edge where `trap_valid` and `trap_ready` are both high. The producer may hold `trap_ready` low for any number of cycles, and the record does not change while it waits.

Top module: `cpop_trap_unit`

## Requirements
- R1: An accepted word with bits [15:12] other than 4'b1111 raises no trap, no abort write and no handshake, and `op_ready` stays high.
- R2: An accepted coprocessor word with bits [8:6] equal to 3'b110 or 3'b111 raises `trap_valid` in the cycle after acceptance, with `cp_started` low.
- R3: An accepted coprocessor word with bits [8:6] in 3'b000..3'b101 and `form_known` low raises `trap_valid` in the cycle after acceptance, with `cp_started` low and no abort write.
- R4: An accepted coprocessor word with bits [8:6] in 3'b000..3'b101 and `form_known` high starts a handshake. `cp_started` goes high in the next cycle. The unit then waits, with `op_ready` low and no trap, for as long as neither `if_bus_err` nor `prim_valid` is high.
- R5: `if_bus_err` high during the handshake raises `trap_valid` in the next cycle with no abort write, whatever the primitive inputs carry.
- R6: With no bus error, a valid primitive whose code is not below PRIM_COUNT (default 12) drives `abort_we` high for exactly one cycle with `abort_mask` equal to ABORT_MASK (default 16'h0001). `trap_valid` follows in the next cycle.
- R7: With no bus error, a primitive code from MEM_PRIM_BASE (default 8) up to PRIM_COUNT-1 needs a memory operand. If the held word's addressing mode bits [5:3] are 3'b000 or 3'b001, it raises `trap_valid` in the next cycle with no abort write. The out-of-range check of R6 takes priority.
- R8: A valid primitive that is in range and compatible ends the handshake with no trap: `op_ready` is high and `cp_started` is low in the next cycle.
- R9: Every trap carries `trap_vector` = 11, `trap_frame` = 4'h0 (the four-word pre-instruction frame) and `trap_pc` equal to the `op_pc` given with the trapping word, so a plain return restarts that instruction.
- R10: While `trap_valid` is high and `trap_ready` is low, the record stays unchanged and `op_ready` stays low. After the acknowledging edge, the unit is idle with `trap_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation word offered |
| op_ready | output | 1 | Unit idle, word will be taken |
| op_word | input | 16 | Operation word |
| op_pc | input | PC_W | Address of the operation word |
| form_known | input | 1 | Word matches a defined coprocessor instruction form |
| if_bus_err | input | 1 | Bus error on the coprocessor interface access |
| prim_valid | input | 1 | Response primitive present |
| prim_code | input | PRIM_W | Response primitive code |
| trap_valid | output | 1 | Trap record offered |
| trap_ready | input | 1 | Trap record accepted |
| trap_vector | output | 8 | Exception vector number |
| trap_frame | output | 4 | Stack frame format code |
| trap_pc | output | PC_W | Program counter to save |
| cp_started | output | 1 | A coprocessor handshake was started for the current word |
| abort_we | output | 1 | Write strobe to the coprocessor control register |
| abort_mask | output | 16 | Value written with the strobe |

## Verification
The bench builds the unit with PC_W = 16, PRIM_W = 4, PRIM_COUNT = 12 and MEM_PRIM_BASE = 8. With these values, all sixteen primitive codes can be driven: codes 0 to 7 are always compatible, 8 to 11 depend on the mode, and 12 to 15 are out of range. All eight [8:6] groups, both values of the form-known flag and all eight addressing modes are crossed with every primitive code. Bus errors are sent together with an out-of-range code, which shows that the bus error wins.

// File: rtl/cpop_trap_pkg.sv
package cpop_trap_pkg;
  localparam logic [7:0] EMU_VECTOR = 8'd11;
  localparam logic [3:0] SHORT_FRAME = 4'h0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ABORT = 2'd2,
    ST_TRAP  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic is_cop;
    logic trap_now;
    logic start_hs;
  } op_class_t;
endpackage

// File: rtl/cpop_op_classify.sv
module cpop_op_classify
  import cpop_trap_pkg::*;
(
  input  logic [3:0] word_top,
  input  logic [2:0] word_grp,
  input  logic       form_known,
  output op_class_t  cls
);
  logic reserved_grp;

  always_comb begin
    reserved_grp = (word_grp == 3'b110) || (word_grp == 3'b111);
    cls.is_cop   = (word_top == 4'hF);
    cls.trap_now = cls.is_cop && (reserved_grp || !form_known);
    cls.start_hs = cls.is_cop && !reserved_grp && form_known;
  end
endmodule

// File: rtl/cpop_prim_check.sv
module cpop_prim_check #(
  parameter int PRIM_W        = 4,
  parameter int PRIM_COUNT    = 12,
  parameter int MEM_PRIM_BASE = 8
) (
  input  logic [PRIM_W-1:0] prim_code,
  input  logic [2:0]        ea_mode,
  output logic              prim_bad,
  output logic              prim_incompat
);
  localparam logic [PRIM_W:0] LIMIT = (PRIM_W+1)'(PRIM_COUNT);
  localparam logic [PRIM_W:0] MEMB  = (PRIM_W+1)'(MEM_PRIM_BASE);

  logic [PRIM_W:0] code_x;
  logic            reg_direct;

  always_comb begin
    code_x        = {1'b0, prim_code};
    reg_direct    = (ea_mode[2:1] == 2'b00);
    prim_bad      = (code_x >= LIMIT);
    prim_incompat = !prim_bad && (code_x >= MEMB) && reg_direct;
  end
endmodule

// File: rtl/cpop_trap_seq.sv
module cpop_trap_seq
  import cpop_trap_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  op_class_t       cls,
  input  logic [2:0]      op_mode,
  input  logic [PC_W-1:0] op_pc,
  input  logic            if_bus_err,
  input  logic            prim_valid,
  input  logic            prim_bad,
  input  logic            prim_incompat,
  input  logic            trap_ready,
  output logic            op_ready,
  output logic            trap_valid,
  output logic            abort_we,
  output logic            cp_started,
  output logic [2:0]      mode_q,
  output logic [PC_W-1:0] pc_q
);
  seq_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cp_started <= 1'b0;
      mode_q     <= '0;
      pc_q       <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (op_valid) begin
          pc_q   <= op_pc;
          mode_q <= op_mode;
          if (cls.trap_now) begin
            state      <= ST_TRAP;
            cp_started <= 1'b0;
          end else if (cls.start_hs) begin
            state      <= ST_WAIT;
            cp_started <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (if_bus_err) state <= ST_TRAP;
          else if (prim_valid) begin
            if (prim_bad)           state <= ST_ABORT;
            else if (prim_incompat) state <= ST_TRAP;
            else begin
              state      <= ST_IDLE;
              cp_started <= 1'b0;
            end
          end
        end
        ST_ABORT: state <= ST_TRAP;
        ST_TRAP: if (trap_ready) begin
          state      <= ST_IDLE;
          cp_started <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign op_ready   = (state == ST_IDLE);
  assign trap_valid = (state == ST_TRAP);
  assign abort_we   = (state == ST_ABORT);
endmodule

// File: rtl/cpop_trap_unit.sv
module cpop_trap_unit
  import cpop_trap_pkg::*;
#(
  parameter int             PC_W          = 32,
  parameter int             PRIM_W        = 4,
  parameter int             PRIM_COUNT    = 12,
  parameter int             MEM_PRIM_BASE = 8,
  parameter logic [15:0]    ABORT_MASK    = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [15:0]       op_word,
  input  logic [PC_W-1:0]   op_pc,
  input  logic              form_known,
  input  logic              if_bus_err,
  input  logic              prim_valid,
  input  logic [PRIM_W-1:0] prim_code,
  output logic              trap_valid,
  input  logic              trap_ready,
  output logic [7:0]        trap_vector,
  output logic [3:0]        trap_frame,
  output logic [PC_W-1:0]   trap_pc,
  output logic              cp_started,
  output logic              abort_we,
  output logic [15:0]       abort_mask
);
  op_class_t  cls;
  logic       prim_bad;
  logic       prim_incompat;
  logic [2:0] mode_q;
  logic       unused_word_bits;

  assign unused_word_bits = ^{op_word[11:9], op_word[2:0]};

  cpop_op_classify u_classify (
    .word_top   (op_word[15:12]),
    .word_grp   (op_word[8:6]),
    .form_known (form_known),
    .cls        (cls)
  );

  cpop_prim_check #(
    .PRIM_W        (PRIM_W),
    .PRIM_COUNT    (PRIM_COUNT),
    .MEM_PRIM_BASE (MEM_PRIM_BASE)
  ) u_prim (
    .prim_code     (prim_code),
    .ea_mode       (mode_q),
    .prim_bad      (prim_bad),
    .prim_incompat (prim_incompat)
  );

  cpop_trap_seq #(.PC_W(PC_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .cls           (cls),
    .op_mode       (op_word[5:3]),
    .op_pc         (op_pc),
    .if_bus_err    (if_bus_err),
    .prim_valid    (prim_valid),
    .prim_bad      (prim_bad),
    .prim_incompat (prim_incompat),
    .trap_ready    (trap_ready),
    .op_ready      (op_ready),
    .trap_valid    (trap_valid),
    .abort_we      (abort_we),
    .cp_started    (cp_started),
    .mode_q        (mode_q),
    .pc_q          (trap_pc)
  );

  assign trap_vector = EMU_VECTOR;
  assign trap_frame  = SHORT_FRAME;
  assign abort_mask  = ABORT_MASK;
endmodule

// File: rtl/cpop_trap_checks.sv
module cpop_trap_checks #(
  parameter int          PC_W       = 32,
  parameter int          PRIM_W     = 4,
  parameter int          PRIM_COUNT = 12,
  parameter logic [15:0] ABORT_MASK = 16'h0001
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [15:0]       op_word,
  input logic [PC_W-1:0]   op_pc,
  input logic              form_known,
  input logic              if_bus_err,
  input logic              prim_valid,
  input logic [PRIM_W-1:0] prim_code,
  input logic              trap_valid,
  input logic              trap_ready,
  input logic [7:0]        trap_vector,
  input logic [3:0]        trap_frame,
  input logic [PC_W-1:0]   trap_pc,
  input logic              cp_started,
  input logic              abort_we,
  input logic [15:0]       abort_mask
);
  logic take;
  logic waiting;
  logic code_oor;
  assign take     = op_valid && op_ready;
  assign waiting  = cp_started && !trap_valid && !abort_we && !op_ready;
  assign code_oor = ({1'b0, prim_code} >= (PRIM_W+1)'(PRIM_COUNT));

  a_r1_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_word[15:12] != 4'hF |=> op_ready && !trap_valid && !abort_we && !cp_started);

  a_r2_reserved_group: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_word[15:12] == 4'hF && op_word[8:7] == 2'b11 |=> trap_valid && !cp_started);

  a_r3_unknown_form: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_word[15:12] == 4'hF && !form_known |=> trap_valid && !cp_started && !abort_we);

  a_r4_handshake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !if_bus_err && !prim_valid |=> waiting);

  a_r5_bus_error: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && if_bus_err |=> trap_valid && !abort_we);

  a_r6_abort_first: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !if_bus_err && prim_valid && code_oor |=> abort_we && abort_mask == ABORT_MASK);

  a_r6_abort_then_trap: assert property (@(posedge clk) disable iff (!rst_n)
    abort_we |=> trap_valid && !abort_we);

  a_r9_trap_fields: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> trap_vector == 8'd11 && trap_frame == 4'h0);

  a_r9_pc_captured: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_word[15:12] == 4'hF && !form_known |=> trap_pc == $past(op_pc));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && !trap_ready |=> trap_valid && $stable(trap_pc) && $stable(cp_started) && !op_ready);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && trap_ready |=> op_ready && !trap_valid);
endmodule

bind cpop_trap_unit cpop_trap_checks #(
  .PC_W(PC_W), .PRIM_W(PRIM_W), .PRIM_COUNT(PRIM_COUNT), .ABORT_MASK(ABORT_MASK)
) u_checks (.*);

// File: tb/test_cpop_trap_unit.sv
`timescale 1ns/1ps
module test_cpop_trap_unit;
  localparam int PC_W = 16;
  localparam int PRIM_W = 4;
  localparam int PRIM_COUNT = 12;
  localparam int MEM_BASE = 8;
  localparam logic [15:0] MASK = 16'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, form_known = 1'b0, if_bus_err = 1'b0, prim_valid = 1'b0, trap_ready = 1'b0;
  logic [15:0] op_word = '0;
  logic [PC_W-1:0] op_pc = '0;
  logic [PRIM_W-1:0] prim_code = '0;
  logic op_ready, trap_valid, cp_started, abort_we;
  logic [7:0] trap_vector;
  logic [3:0] trap_frame;
  logic [PC_W-1:0] trap_pc;
  logic [15:0] abort_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpop_trap_unit #(.PC_W(PC_W), .PRIM_W(PRIM_W), .PRIM_COUNT(PRIM_COUNT),
                   .MEM_PRIM_BASE(MEM_BASE), .ABORT_MASK(MASK)) i_cpop_trap_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_word(op_word), .op_pc(op_pc), .form_known(form_known),
    .if_bus_err(if_bus_err), .prim_valid(prim_valid), .prim_code(prim_code),
    .trap_valid(trap_valid), .trap_ready(trap_ready), .trap_vector(trap_vector),
    .trap_frame(trap_frame), .trap_pc(trap_pc), .cp_started(cp_started),
    .abort_we(abort_we), .abort_mask(abort_mask));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic idle_drive();
    op_valid = 0; if_bus_err = 0; prim_valid = 0; trap_ready = 0;
  endtask

  task automatic issue(logic [15:0] w, logic f, logic [PC_W-1:0] pc);
    @(negedge clk);
    idle_drive();
    op_valid = 1; op_word = w; form_known = f; op_pc = pc;
    @(posedge clk); #1;
  endtask

  task automatic respond(logic be, logic pv, logic [PRIM_W-1:0] code);
    @(negedge clk);
    idle_drive();
    if_bus_err = be; prim_valid = pv; prim_code = code;
    @(posedge clk); #1;
  endtask

  task automatic step();
    @(negedge clk);
    idle_drive();
    @(posedge clk); #1;
  endtask

  // checks a pending trap record, holds it one cycle, then acknowledges
  task automatic check_trap(string tag, logic [PC_W-1:0] pc, logic cp);
    chk({tag, " R9 valid"}, trap_valid, 1);
    chk({tag, " R9 vector"}, trap_vector, 11);
    chk({tag, " R9 frame"}, trap_frame, 0);
    chk({tag, " R9 pc"}, trap_pc, pc);
    chk({tag, " cp_started"}, cp_started, cp);
    step();
    chk({tag, " R10 held"}, trap_valid, 1);
    chk({tag, " R10 pc stable"}, trap_pc, pc);
    chk({tag, " R10 no accept"}, op_ready, 0);
    @(negedge clk);
    idle_drive(); trap_ready = 1;
    @(posedge clk); #1;
    chk({tag, " R10 released"}, {trap_valid, op_ready, cp_started}, 3'b010);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [PC_W-1:0] pc;
    pc = 16'h0100;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("reset op_ready", op_ready, 1);
    chk("reset trap", {trap_valid, abort_we, cp_started}, 0);

    // R1: every non-coprocessor top nibble, with bits that would trap otherwise
    for (int t = 0; t < 15; t++) begin
      issue({t[3:0], 12'h1C0}, 1'b0, pc);
      chk("R1 no effect", {trap_valid, abort_we, cp_started, op_ready}, 4'b0001);
      pc++;
    end

    for (int g = 0; g < 8; g++) begin
      for (int f = 0; f < 2; f++) begin
        for (int m = 0; m < 8; m++) begin
          logic [15:0] w;
          w = {4'hF, 3'b001, g[2:0], m[2:0], 3'b010};
          if (g >= 6 || f == 0) begin
            issue(w, f[0], pc);
            chk(g >= 6 ? "R2 abort none" : "R3 abort none", abort_we, 0);
            check_trap(g >= 6 ? "R2" : "R3", pc, 1'b0);
            pc++;
          end else begin
            for (int c = 0; c < 17; c++) begin
              logic be;
              logic [PRIM_W-1:0] code;
              be = (c == 16);
              code = be ? 4'hF : c[3:0];
              issue(w, 1'b1, pc);
              chk("R4 started", {cp_started, trap_valid, op_ready}, 3'b100);
              if (c == 0) begin
                step();
                chk("R4 waiting", {cp_started, trap_valid, op_ready, abort_we}, 4'b1000);
              end
              respond(be, 1'b1, code);
              if (be) begin
                chk("R5 no abort", abort_we, 0);
                check_trap("R5", pc, 1'b1);
              end else if (c >= PRIM_COUNT) begin
                chk("R6 abort strobe", {abort_we, trap_valid}, 2'b10);
                chk("R6 abort mask", abort_mask, MASK);
                step();
                chk("R6 single strobe", abort_we, 0);
                check_trap("R6", pc, 1'b1);
              end else if (c >= MEM_BASE && m < 2) begin
                chk("R7 no abort", abort_we, 0);
                check_trap("R7", pc, 1'b1);
              end else begin
                chk("R8 completes", {op_ready, cp_started, trap_valid, abort_we}, 4'b1000);
              end
              pc++;
            end
          end
        end
      end
    end
    finish_run();
  end
endmodule